// File: doc/BRIEF.md
# Bridgeless Rectifier Gate Steering

This block sits between a PWM generator and the four gate drivers of a bridgeless boost rectifier. It takes signed samples of the line node and the neutral node, subtracts them to get the AC input voltage, and decides which half cycle the converter is in. It then sends the duty-controlled PWM signal and its complement to the two fast switches. It also sets the two slow-leg switches statically for the whole half cycle.

A hysteresis band around zero keeps the polarity decision from chattering near the zero crossing. Whenever the decision changes, all four gates are held off for a programmable number of clock cycles before the new routing takes effect. The first decision after reset is treated the same way. A global enable forces every gate low. Dead time, PWM generation and current control happen upstream and are not part of this block.

Naming of the four outputs:
- `gate_hf_a` and `gate_hf_b` drive the fast pair.
- `gate_slow_a` and `gate_slow_b` drive the slow leg.

Top module: `bridge_gate_steer`

## Requirements
- R1: After reset all four gates are low, and they stay low until a polarity decision has been made, whatever the PWM inputs do.
- R2: On each strobe the block computes diff = line_smp − neut_smp with full precision. The polarity becomes positive only if diff > hyst_th, and negative only if diff < −hyst_th. A diff inside the closed band [−hyst_th, +hyst_th] keeps the previous polarity.
- R3: In the positive polarity the outputs are as follows.
  - gate_hf_b follows pwm_d.
  - gate_hf_a follows pwm_dn.
  - gate_slow_b is high.
  - gate_slow_a is low.
- R4: In the negative polarity the outputs are as follows.
  - gate_hf_a follows pwm_d.
  - gate_hf_b follows pwm_dn.
  - gate_slow_a is high.
  - gate_slow_b is low.
- R5: The samples are evaluated only on a clock edge where smp_valid is high. Changes to the samples without the strobe have no effect on the gates.
- R6: Suppose a strobe at clock edge k changes the polarity decision, including the first decision after reset. Then all gates are low from edge k+1 for blank_cyc+1 clock cycles, and the new routing applies from edge k+blank_cyc+2.
- R7: While en is low all four gates are low in the same cycle (with the registered-output variant, from the next edge). Polarity tracking continues while en is low, so the correct routing is present as soon as en returns high.
- R8: If the polarity decision changes again while gates are blanked, the blanking interval restarts from blank_cyc, counted from the edge after the new decision.
- R9: The two slow-leg gates are never high together. Neither slow-leg gate goes high in the cycle right after the other one was high.
- R10: A fast gate is high only when the PWM input routed to it by the current polarity is high. The fast pair therefore keeps the complementary relation of pwm_d and pwm_dn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Global gate enable |
| smp_valid | input | 1 | Sample strobe; samples are evaluated on edges where it is high |
| line_smp | input | SAMPLE_W | Signed line-node sample |
| neut_smp | input | SAMPLE_W | Signed neutral-node sample |
| hyst_th | input | SAMPLE_W | Unsigned hysteresis threshold |
| blank_cyc | input | CNT_W | Blanking length; gates are off for blank_cyc+1 cycles on a polarity change |
| pwm_d | input | 1 | Duty-controlled PWM signal |
| pwm_dn | input | 1 | Complementary PWM signal |
| gate_hf_a | output | 1 | Fast switch A gate (gets pwm_d in the negative half cycle) |
| gate_hf_b | output | 1 | Fast switch B gate (gets pwm_d in the positive half cycle) |
| gate_slow_a | output | 1 | Slow switch A gate (on in the negative half cycle) |
| gate_slow_b | output | 1 | Slow switch B gate (on in the positive half cycle) |

## Verification
A wrong polarity register appears at the ports as a swapped slow leg and a fast pair routed the wrong way. This shows within blank_cyc+2 cycles of the strobe that should have set the polarity. A stuck or miscounted blanking counter shows as an off window that is too short or too long. The bench checks this window on its exact first and last cycles, both for a single change and for a change that restarts the window. A wrong hysteresis comparison shows only on samples at or just beyond the band edge, so the stimulus table includes diffs exactly at ±hyst_th and one count past it, as well as full-scale samples.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
   typedef enum logic [1:0] {
      POL_NONE = 2'b00,
      POL_POS  = 2'b01,
      POL_NEG  = 2'b10
   } pol_e;
endpackage

// File: rtl/bgs_polarity_det.sv
module bgs_polarity_det
   import bgs_pkg::*;
#(
   parameter int SAMPLE_W = 13
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       smp_valid,
   input  logic signed [SAMPLE_W-1:0] line_smp,
   input  logic signed [SAMPLE_W-1:0] neut_smp,
   input  logic        [SAMPLE_W-1:0] hyst_th,
   output pol_e                       pol_o
);
   localparam int DIFF_W = SAMPLE_W + 1;

   logic signed [DIFF_W-1:0] diff;
   logic signed [DIFF_W-1:0] th_hi;
   logic signed [DIFF_W-1:0] th_lo;
   pol_e                     pol_q;

   // Sign-extend both samples so the difference cannot overflow.
   assign diff  = $signed({line_smp[SAMPLE_W-1], line_smp})
                - $signed({neut_smp[SAMPLE_W-1], neut_smp});
   assign th_hi = $signed({1'b0, hyst_th});
   assign th_lo = -th_hi;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pol_q <= POL_NONE;
      end else if (smp_valid) begin
         if (diff > th_hi) begin
            pol_q <= POL_POS;
         end else if (diff < th_lo) begin
            pol_q <= POL_NEG;
         end
      end
   end

   assign pol_o = pol_q;
endmodule

// File: rtl/bgs_swap_blanker.sv
module bgs_swap_blanker
   import bgs_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  pol_e             pol_det,
   input  logic [CNT_W-1:0] blank_cyc,
   output pol_e             pol_act
);
   pol_e             target_q;
   pol_e             act_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         target_q <= POL_NONE;
         act_q    <= POL_NONE;
         cnt_q    <= '0;
      end else if (pol_det != target_q) begin
         // New decision: drop the routing and (re)start the off window.
         target_q <= pol_det;
         act_q    <= POL_NONE;
         cnt_q    <= blank_cyc;
      end else if (act_q != target_q) begin
         if (cnt_q == '0) begin
            act_q <= target_q;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign pol_act = act_q;
endmodule

// File: rtl/bgs_gate_route.sv
module bgs_gate_route
   import bgs_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  pol_e       pol_act,
   input  logic       pwm_d,
   input  logic       pwm_dn,
   output logic [3:0] gates   // {hf_a, hf_b, slow_a, slow_b}
);
   logic [3:0] route;
   logic [3:0] masked;

   always_comb begin
      route = 4'b0000;
      case (pol_act)
         POL_POS: route = {pwm_dn, pwm_d, 1'b0, 1'b1};
         POL_NEG: route = {pwm_d, pwm_dn, 1'b1, 1'b0};
         default: route = 4'b0000;
      endcase
      masked = en ? route : 4'b0000;
   end

   generate
      if (OUT_REG) begin : g_reg
         logic [3:0] gates_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               gates_q <= '0;
            end else begin
               gates_q <= masked;
            end
         end
         assign gates = gates_q;
      end else begin : g_comb
         assign gates = masked;
      end
   endgenerate
endmodule

// File: rtl/bridge_gate_steer.sv
module bridge_gate_steer
   import bgs_pkg::*;
#(
   parameter int SAMPLE_W = 13,
   parameter int CNT_W    = 8,
   parameter bit OUT_REG  = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       en,
   input  logic                       smp_valid,
   input  logic signed [SAMPLE_W-1:0] line_smp,
   input  logic signed [SAMPLE_W-1:0] neut_smp,
   input  logic        [SAMPLE_W-1:0] hyst_th,
   input  logic        [CNT_W-1:0]    blank_cyc,
   input  logic                       pwm_d,
   input  logic                       pwm_dn,
   output logic                       gate_hf_a,
   output logic                       gate_hf_b,
   output logic                       gate_slow_a,
   output logic                       gate_slow_b
);
   generate
      if (SAMPLE_W < 4 || SAMPLE_W > 32) begin : g_bad_sample_w
         $error("bridge_gate_steer: SAMPLE_W must be 4..32");
      end
      if (CNT_W < 1 || CNT_W > 24) begin : g_bad_cnt_w
         $error("bridge_gate_steer: CNT_W must be 1..24");
      end
   endgenerate

   pol_e       pol_det;
   pol_e       pol_act;
   logic [3:0] gates;

   bgs_polarity_det #(.SAMPLE_W(SAMPLE_W)) u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .line_smp  (line_smp),
      .neut_smp  (neut_smp),
      .hyst_th   (hyst_th),
      .pol_o     (pol_det)
   );

   bgs_swap_blanker #(.CNT_W(CNT_W)) u_blank (
      .clk       (clk),
      .rst_n     (rst_n),
      .pol_det   (pol_det),
      .blank_cyc (blank_cyc),
      .pol_act   (pol_act)
   );

   bgs_gate_route #(.OUT_REG(OUT_REG)) u_route (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .pol_act (pol_act),
      .pwm_d   (pwm_d),
      .pwm_dn  (pwm_dn),
      .gates   (gates)
   );

   assign {gate_hf_a, gate_hf_b, gate_slow_a, gate_slow_b} = gates;
endmodule

// File: rtl/bgs_checker.sv
module bgs_checker #(
   parameter bit OUT_REG = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic pwm_d,
   input logic pwm_dn,
   input logic gate_hf_a,
   input logic gate_hf_b,
   input logic gate_slow_a,
   input logic gate_slow_b
);
   p_slow_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_slow_a && gate_slow_b));

   p_slow_a_to_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
      gate_slow_a |=> !gate_slow_b);

   p_slow_b_to_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
      gate_slow_b |=> !gate_slow_a);

   p_fast_needs_slow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_hf_a || gate_hf_b) |-> (gate_slow_a || gate_slow_b));

   generate
      if (OUT_REG) begin : g_reg_chk
         p_enable_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !en |=> !(gate_hf_a || gate_hf_b || gate_slow_a || gate_slow_b));
      end else begin : g_comb_chk
         p_enable_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !en |-> !(gate_hf_a || gate_hf_b || gate_slow_a || gate_slow_b));
         p_hfb_pos_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_hf_b && gate_slow_b) |-> pwm_d);
         p_hfa_pos_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_hf_a && gate_slow_b) |-> pwm_dn);
         p_hfa_neg_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_hf_a && gate_slow_a) |-> pwm_d);
         p_hfb_neg_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_hf_b && gate_slow_a) |-> pwm_dn);
      end
   endgenerate
endmodule

bind bridge_gate_steer bgs_checker #(.OUT_REG(OUT_REG)) u_bgs_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .en          (en),
   .pwm_d       (pwm_d),
   .pwm_dn      (pwm_dn),
   .gate_hf_a   (gate_hf_a),
   .gate_hf_b   (gate_hf_b),
   .gate_slow_a (gate_slow_a),
   .gate_slow_b (gate_slow_b)
);

// File: tb/tb_bridge_gate_steer.sv
module tb_bridge_gate_steer;
   localparam int SW = 13;
   localparam int CW = 8;
   localparam int NB = 3;   // blanking length used by most tests
   localparam int NV = 12;

   // {line, neut, threshold, expected polarity (1 pos, 2 neg), 1 = band hold}
   localparam logic [41:0] VEC [NV] = '{
      {13'sd1000,  13'sd0,     13'd100,  2'd1, 1'b0},
      {13'sd50,    13'sd0,     13'd100,  2'd1, 1'b1},
      {-13'sd50,   13'sd0,     13'd100,  2'd1, 1'b1},
      {-13'sd200,  13'sd0,     13'd100,  2'd2, 1'b0},
      {13'sd0,     13'sd101,   13'd100,  2'd2, 1'b0},
      {13'sd100,   13'sd0,     13'd100,  2'd2, 1'b1},
      {13'sd101,   13'sd0,     13'd100,  2'd1, 1'b0},
      {-13'sd4096, 13'sd4095,  13'd0,    2'd2, 1'b0},
      {13'sd4095,  -13'sd4096, 13'd8191, 2'd2, 1'b1},
      {13'sd4095,  -13'sd4096, 13'd8190, 2'd1, 1'b0},
      {13'sd0,     -13'sd100,  13'd100,  2'd1, 1'b1},
      {13'sd0,     13'sd1,     13'd0,    2'd2, 1'b0}
   };

   logic                 clk = 1'b0;
   logic                 rst_n;
   logic                 en;
   logic                 smp_valid;
   logic signed [SW-1:0] line_smp;
   logic signed [SW-1:0] neut_smp;
   logic        [SW-1:0] hyst_th;
   logic        [CW-1:0] blank_cyc;
   logic                 pwm_d;
   logic                 pwm_dn;
   logic                 gate_hf_a, gate_hf_b, gate_slow_a, gate_slow_b;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   bridge_gate_steer #(.SAMPLE_W(SW), .CNT_W(CW), .OUT_REG(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .en(en), .smp_valid(smp_valid),
      .line_smp(line_smp), .neut_smp(neut_smp), .hyst_th(hyst_th),
      .blank_cyc(blank_cyc), .pwm_d(pwm_d), .pwm_dn(pwm_dn),
      .gate_hf_a(gate_hf_a), .gate_hf_b(gate_hf_b),
      .gate_slow_a(gate_slow_a), .gate_slow_b(gate_slow_b)
   );

   function automatic logic [3:0] exp_gates(input int pol, input logic d);
      if (pol == 1) return {~d, d, 1'b0, 1'b1};
      if (pol == 2) return {d, ~d, 1'b1, 1'b0};
      return 4'b0000;
   endfunction

   task automatic chk(input logic [3:0] exp, input string tag);
      logic [3:0] got;
      got = {gate_hf_a, gate_hf_b, gate_slow_a, gate_slow_b};
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: gates=%b expected=%b", tag, got, exp);
      end
   endtask

   task automatic set_pwm(input logic d);
      pwm_d  = d;
      pwm_dn = ~d;
      #1;
   endtask

   task automatic strobe(input logic signed [SW-1:0] l, input logic signed [SW-1:0] n);
      @(negedge clk);
      line_smp  = l;
      neut_smp  = n;
      smp_valid = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; en = 1'b1; smp_valid = 1'b0;
      line_smp = '0; neut_smp = '0; hyst_th = 13'd100;
      blank_cyc = CW'(NB); pwm_d = 1'b1; pwm_dn = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1: off after reset for either PWM level
      set_pwm(1'b1); chk(4'b0000, "R1 reset pwm high");
      set_pwm(1'b0); chk(4'b0000, "R1 reset pwm low");

      // R6: first decision, exact off window
      set_pwm(1'b1);
      strobe(13'sd1000, 13'sd0);
      @(negedge clk); #1 chk(4'b0000, "R6 window first cycle");
      repeat (NB) @(negedge clk);
      #1 chk(4'b0000, "R6 window last cycle");
      @(negedge clk); #1 chk(exp_gates(1, 1'b1), "R6 routing applied");

      // R2 / R3 / R4: table walk
      for (int i = 0; i < NV; i++) begin
         int         pol;
         logic [41:0] v;
         v       = VEC[i];
         pol     = int'(v[2:1]);
         hyst_th = v[15:3];
         strobe($signed(v[41:29]), $signed(v[28:16]));
         repeat (NB + 2) @(negedge clk);
         for (int d = 0; d < 2; d++) begin
            set_pwm(d[0]);
            chk(exp_gates(pol, d[0]),
                $sformatf("%s vec %0d d=%0d", v[0] ? "R2 hold" :
                          (pol == 1 ? "R3 pos" : "R4 neg"), i, d));
         end
      end

      // R5: samples move without strobe
      hyst_th  = 13'd100;
      line_smp = 13'sd2000; neut_smp = -13'sd2000;
      repeat (20) @(negedge clk);
      set_pwm(1'b1); chk(exp_gates(2, 1'b1), "R5 no strobe no change");

      // R7: enable masking, tracking continues
      en = 1'b0; #1 chk(4'b0000, "R7 disable immediate");
      strobe(13'sd1000, 13'sd0);
      repeat (NB + 2) @(negedge clk);
      #1 chk(4'b0000, "R7 still off while disabled");
      en = 1'b1; #1 chk(exp_gates(1, 1'b1), "R7 re-enable new polarity");

      // R8: second change while blanked restarts window
      strobe(-13'sd1000, 13'sd0);
      strobe(13'sd1000, 13'sd0);
      repeat (NB + 1) @(negedge clk);
      #1 chk(4'b0000, "R8 restarted window last cycle");
      @(negedge clk); #1 chk(exp_gates(1, 1'b1), "R8 routing after restart");

      // R6 / R9: zero-length setting still gives one off cycle
      blank_cyc = '0;
      strobe(-13'sd1000, 13'sd0);
      @(negedge clk); #1 chk(4'b0000, "R6 R9 single off cycle");
      @(negedge clk); set_pwm(1'b0); chk(exp_gates(2, 1'b0), "R6 R10 negative after one cycle");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule